// File: doc/BRIEF.md
# GPIO Pin Configuration Controller

The block is a register-mapped controller for up to 32 general-purpose I/O pins. It holds a direction word, an output word and a synchronized input word for the port. It also holds one configuration byte for each pin. A single write strobe on a byte-addressable register bus updates these registers.

For each pin, the configuration byte decides who drives the pad. Either the port's direction and output bits drive it, or an alternate peripheral drives it through its own direction and output lines. The byte also decides whether the pad level is sampled at all. Sampling goes through a two-flop synchronizer and ends in the read-only input word. Sampling still works while the peripheral owns the pad.

The controller also produces the pad's pull and slew-limit controls. Each control is qualified by the pin's current direction. A write-protect input freezes all configuration bytes. The direction and output words stay writable while it is asserted.

Top module: `gpio_pincfg_ctrl`

## Requirements
- R1: After reset, every configuration byte reads 0x00. The direction, output and input words read zero, and all pad control outputs are low.
- R2: The configuration byte of pin n sits at byte address 0x40+n. It is reached as bus word 0x40+4*(n/4), byte lane n%4, data bits [8*(n%4)+7 : 8*(n%4)]. Within the byte, bit 0 is peripheral-drive enable, bit 1 is input-sample enable, bit 2 is pull enable and bit 4 is slew-limit enable. A write updates only the pins whose lane strobe in bus_be_i is set.
- R3: Configuration bits 3, 5, 6 and 7 cannot be set and always read as zero.
- R4: With peripheral-drive enable at 0, pad_oe_o equals the pin's direction bit and pad_out_o equals its output bit. The peripheral's direction and output inputs have no effect on the pad.
- R5: With peripheral-drive enable at 1, pad_oe_o follows periph_oe_i and pad_out_o follows periph_out_i. The direction and output bits have no effect on the pad.
- R6: With input-sample enable at 0, the pin's bit in the input word reads 0 whatever the pad level. This holds from the clock edge that clears the enable, whether the pin is an input or an output.
- R7: With input-sample enable at 1, the input word bit shows the pad level sampled two clock edges earlier. This also holds while the peripheral or the direction bit drives the pad.
- R8: pad_pull_o is high only when pull enable is 1 and the pad is not output-enabled. pad_slew_o is high only when slew-limit enable is 1 and the pad is output-enabled.
- R9: While wprot_i is high, writes to configuration bytes have no effect. Writes to the direction and output words still take effect.
- R10: The direction word is at 0x00 and the output word is at 0x10. Both are read/write with byte strobes, and a write is visible after the clock edge that takes it. The input word is at 0x20, is read-only, and ignores writes.
- R11: Reads of unmapped or unaligned addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_be_i | input | 4 | Byte-lane write strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address while a read is requested |
| wprot_i | input | 1 | Write protection for the configuration bytes |
| periph_oe_i | input | NUM_PINS | Peripheral per-pin direction (1 = drive) |
| periph_out_i | input | NUM_PINS | Peripheral per-pin output value |
| pad_in_i | input | NUM_PINS | Pad levels |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_out_o | output | NUM_PINS | Pad output value |
| pad_pull_o | output | NUM_PINS | Pad pull-resistor enable |
| pad_slew_o | output | NUM_PINS | Pad slew-limit enable |

## Verification
The bench builds the block with NUM_PINS = 32, ADDR_W = 8 and SYNC_STAGES = 2. This gives the full 32-pin map, so all eight configuration words from 0x40 to 0x5C are live. It also makes the first unmapped word at 0x60 and the word gaps at 0x04 and 0x30 reachable. Every byte lane of every register can be addressed. With two synchronizer stages, the bench can check input read-back one edge early, when it must still show the old level, and then exactly on the second edge.

// File: rtl/gpio_pincfg_pkg.sv
package gpio_pincfg_pkg;
  localparam int unsigned DIR_OFS  = 32'h00;
  localparam int unsigned OUT_OFS  = 32'h10;
  localparam int unsigned IN_OFS   = 32'h20;
  localparam int unsigned CFG_BASE = 32'h40;

  localparam int unsigned BIT_PMUX = 0;
  localparam int unsigned BIT_INEN = 1;
  localparam int unsigned BIT_PULL = 2;
  localparam int unsigned BIT_SLEW = 4;

  typedef struct packed {
    logic slew;
    logic pull;
    logic inen;
    logic pmux;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_from_byte(input logic [7:0] b);
    pin_cfg_t c;
    c.pmux = b[BIT_PMUX];
    c.inen = b[BIT_INEN];
    c.pull = b[BIT_PULL];
    c.slew = b[BIT_SLEW];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
    logic [7:0] b;
    b = '0;
    b[BIT_PMUX] = c.pmux;
    b[BIT_INEN] = c.inen;
    b[BIT_PULL] = c.pull;
    b[BIT_SLEW] = c.slew;
    return b;
  endfunction
endpackage

// File: rtl/gpio_pincfg_regs.sv
module gpio_pincfg_regs
  import gpio_pincfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [3:0]          be_i,
  input  logic [31:0]         wdata_i,
  input  logic                wprot_i,
  input  logic [NUM_PINS-1:0] in_val_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o,
  output pin_cfg_t            cfg_o [NUM_PINS]
);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OUT_OFS);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(IN_OFS);

  logic wr, rd, hit_dir, hit_out, hit_in;
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign hit_dir = (addr_i == A_DIR);
  assign hit_out = (addr_i == A_OUT);
  assign hit_in  = (addr_i == A_IN);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned LANE = i % 4;
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_BASE + 4 * (i / 4));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_o[i] <= 1'b0;
        out_o[i] <= 1'b0;
      end else begin
        if (wr && hit_dir && be_i[i/8]) dir_o[i] <= wdata_i[i];
        if (wr && hit_out && be_i[i/8]) out_o[i] <= wdata_i[i];
      end
    end

    // configuration byte, write-protected
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[i] <= '0;
      end else if (wr && !wprot_i && addr_i == A_CFG && be_i[LANE]) begin
        cfg_o[i] <= cfg_from_byte(wdata_i[8*LANE +: 8]);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit_dir) rdata_o[NUM_PINS-1:0] = dir_o;
      if (hit_out) rdata_o[NUM_PINS-1:0] = out_o;
      if (hit_in)  rdata_o[NUM_PINS-1:0] = in_val_i;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (addr_i == ADDR_W'(CFG_BASE + 4 * (i / 4)))
          rdata_o[8*(i%4) +: 8] = cfg_to_byte(cfg_o[i]);
      end
    end
  end
endmodule

// File: rtl/gpio_pincfg_insync.sv
module gpio_pincfg_insync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] en_i,
  output logic [NUM_PINS-1:0] val_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= pad_i & en_i;
      end else begin
        // a disabled pin flushes its whole chain
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1] & en_i;
      end
    end
  end

  assign val_o = stage_q[STAGES-1] & en_i;
endmodule

// File: rtl/gpio_pincfg_pad.sv
module gpio_pincfg_pad
  import gpio_pincfg_pkg::*;
(
  input  pin_cfg_t cfg_i,
  input  logic     dir_i,
  input  logic     port_out_i,
  input  logic     periph_oe_i,
  input  logic     periph_out_i,
  output logic     oe_o,
  output logic     out_o,
  output logic     pull_o,
  output logic     slew_o
);
  assign oe_o   = cfg_i.pmux ? periph_oe_i  : dir_i;
  assign out_o  = cfg_i.pmux ? periph_out_i : port_out_i;
  assign pull_o = cfg_i.pull & ~oe_o;
  assign slew_o = cfg_i.slew & oe_o;
endmodule

// File: rtl/gpio_pincfg_ctrl.sv
module gpio_pincfg_ctrl
  import gpio_pincfg_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [3:0]          bus_be_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic                wprot_i,
  input  logic [NUM_PINS-1:0] periph_oe_i,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pull_o,
  output logic [NUM_PINS-1:0] pad_slew_o
);
  logic [NUM_PINS-1:0]   dir_q, out_q, in_q, in_en, pmux_en;
  logic [8*NUM_PINS-1:0] cfg_flat;
  pin_cfg_t              cfg_q [NUM_PINS];

  gpio_pincfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .wprot_i  (wprot_i),
    .in_val_i (in_q),
    .rdata_o  (bus_rdata_o),
    .dir_o    (dir_q),
    .out_o    (out_q),
    .cfg_o    (cfg_q)
  );

  gpio_pincfg_insync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .en_i   (in_en),
    .val_o  (in_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
    assign in_en[i]           = cfg_q[i].inen;
    assign pmux_en[i]         = cfg_q[i].pmux;
    assign cfg_flat[8*i +: 8] = cfg_to_byte(cfg_q[i]);

    gpio_pincfg_pad u_pad (
      .cfg_i        (cfg_q[i]),
      .dir_i        (dir_q[i]),
      .port_out_i   (out_q[i]),
      .periph_oe_i  (periph_oe_i[i]),
      .periph_out_i (periph_out_i[i]),
      .oe_o         (pad_oe_o[i]),
      .out_o        (pad_out_o[i]),
      .pull_o       (pad_pull_o[i]),
      .slew_o       (pad_slew_o[i])
    );
  end
endmodule

// File: rtl/gpio_pincfg_chk.sv
module gpio_pincfg_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_req_i,
  input logic                  bus_we_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [31:0]           bus_rdata_o,
  input logic                  wprot_i,
  input logic [NUM_PINS-1:0]   periph_oe_i,
  input logic [NUM_PINS-1:0]   periph_out_i,
  input logic [NUM_PINS-1:0]   pad_in_i,
  input logic [NUM_PINS-1:0]   pad_oe_o,
  input logic [NUM_PINS-1:0]   pad_out_o,
  input logic [NUM_PINS-1:0]   pad_pull_o,
  input logic [NUM_PINS-1:0]   pad_slew_o,
  input logic [NUM_PINS-1:0]   dir_q,
  input logic [NUM_PINS-1:0]   out_q,
  input logic [NUM_PINS-1:0]   in_q,
  input logic [NUM_PINS-1:0]   in_en,
  input logic [NUM_PINS-1:0]   pmux_en,
  input logic [8*NUM_PINS-1:0] cfg_flat
);
  logic [1:0] settle_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            settle_q <= '0;
    else if (settle_q != 3) settle_q <= settle_q + 2'd1;
  end

  p_wprot_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && wprot_i) |=> $stable(cfg_flat));

  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i >= ADDR_W'(8'h40) && bus_addr_i < ADDR_W'(8'h60))
      |-> ((bus_rdata_o & 32'hE8E8_E8E8) == 32'h0));

  p_unaligned_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_o == 32'h0));

  p_port_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pmux_en & ((pad_oe_o ^ dir_q) | (pad_out_o ^ out_q))) == '0));

  p_periph_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pmux_en & ((pad_oe_o ^ periph_oe_i) | (pad_out_o ^ periph_out_i))) == '0));

  p_in_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((in_q & ~in_en) == '0));

  p_in_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_q == 3 && in_en == $past(in_en) && in_en == $past(in_en, 2))
      |-> (in_q == ($past(pad_in_i, 2) & in_en)));

  p_pull_input_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pull_o & pad_oe_o) == '0));

  p_slew_output_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_slew_o & ~pad_oe_o) == '0));
endmodule

bind gpio_pincfg_ctrl gpio_pincfg_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .wprot_i      (wprot_i),
  .periph_oe_i  (periph_oe_i),
  .periph_out_i (periph_out_i),
  .pad_in_i     (pad_in_i),
  .pad_oe_o     (pad_oe_o),
  .pad_out_o    (pad_out_o),
  .pad_pull_o   (pad_pull_o),
  .pad_slew_o   (pad_slew_o),
  .dir_q        (dir_q),
  .out_q        (out_q),
  .in_q         (in_q),
  .in_en        (in_en),
  .pmux_en      (pmux_en),
  .cfg_flat     (cfg_flat)
);

// File: tb/gpio_pincfg_ctrl_test.sv
`timescale 1ns/1ps
module gpio_pincfg_ctrl_test;
  localparam int unsigned NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, wprot = 1'b0;
  logic [7:0]    addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NP-1:0] p_oe = '0, p_out = '0, pad_in = '0;
  logic [NP-1:0] oe, out, pull, slew;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  gpio_pincfg_ctrl #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wprot_i(wprot), .periph_oe_i(p_oe), .periph_out_i(p_out), .pad_in_i(pad_in),
    .pad_oe_o(oe), .pad_out_o(out), .pad_pull_o(pull), .pad_slew_o(slew)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd_chk("R1 dir reset", 8'h00, 32'h0);
    rd_chk("R1 out reset", 8'h10, 32'h0);
    rd_chk("R1 in reset",  8'h20, 32'h0);
    for (int w = 0; w < 8; w++) rd_chk("R1 cfg reset", 8'h40 + 8'(4*w), 32'h0);
    chk("R1 pad_oe reset", oe, 32'h0);
    chk("R1 pad_pull/slew reset", pull | slew | out, 32'h0);
  endtask

  task automatic t_layout;
    wr(8'h44, 4'b0100, 32'hFFFF_FFFF);      // pin 6 only
    @(negedge clk);
    rd_chk("R2 R3 lane 2 of word 0x44", 8'h44, 32'h0017_0000);
    wr(8'h5C, 4'b1001, 32'h1602_0215);      // pins 28 and 31
    @(negedge clk);
    rd_chk("R2 lane select word 0x5C", 8'h5C, 32'h1600_0015);
    wr(8'h44, 4'b1111, 32'h0);
    wr(8'h5C, 4'b1111, 32'h0);
    @(negedge clk);
    rd_chk("R2 cfg cleared", 8'h44, 32'h0);
  endtask

  task automatic t_port_drive;
    wr(8'h00, 4'b1111, 32'h0000_FFFF);
    wr(8'h10, 4'b1111, 32'h00FF_00FF);
    p_oe = '1; p_out = 32'hFF00_FF00;
    @(negedge clk);
    chk("R4 pad_oe from dir", oe, 32'h0000_FFFF);
    chk("R4 pad_out from out", out, 32'h00FF_00FF);
    wr(8'h00, 4'b0100, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R10 dir byte strobe", 8'h00, 32'h00FF_FFFF);
    chk("R4 pad_oe after strobe write", oe, 32'h00FF_FFFF);
  endtask

  task automatic t_periph;
    wr(8'h00, 4'b1111, 32'hFFFF_0000);
    wr(8'h10, 4'b1111, 32'h0000_FF0F);
    wr(8'h40, 4'b1111, 32'h0101_0101);      // pins 0..3 to peripheral
    p_oe = 32'h0000_0005; p_out = 32'h0000_000A;
    @(negedge clk);
    chk("R5 pad_oe mixed", oe, 32'hFFFF_0005);
    chk("R5 pad_out mixed", out, 32'h0000_FF0A);
    p_oe = 32'h0000_000A;
    #1 chk("R5 pad_oe follows periph", oe, 32'hFFFF_000A);
  endtask

  task automatic t_input;
    pad_in = '0;
    wr(8'h40, 4'b1111, 32'h0303_0303);      // pins 0..3 peripheral + sample
    wr(8'h48, 4'b1111, 32'h0202_0202);      // pins 8..11 sample
    wr(8'h00, 4'b0010, 32'h0000_0100);      // pin 8 output
    repeat (3) @(negedge clk);
    pad_in = 32'hA5A5_A5A5;
    @(negedge clk);
    rd_chk("R7 one edge early", 8'h20, 32'h0);
    @(negedge clk);
    rd_chk("R7 after two edges", 8'h20, 32'h0000_0505);
    wr(8'h48, 4'b1111, 32'h0);
    rd_chk("R6 disable clears at once", 8'h20, 32'h0000_0005);
    pad_in = '1;
    repeat (3) @(negedge clk);
    rd_chk("R6 R7 unsampled pins stay 0", 8'h20, 32'h0000_000F);
    wr(8'h20, 4'b1111, 32'h0);
    rd_chk("R10 in read-only", 8'h20, 32'h0000_000F);
    wr(8'h40, 4'b1111, 32'h0);
  endtask

  task automatic t_pull_slew;
    p_oe = '0;
    wr(8'h00, 4'b1111, 32'h0003_0000);
    wr(8'h50, 4'b1111, 32'h1414_1414);      // pins 16..19 pull + slew
    @(negedge clk);
    chk("R8 pull only on inputs", pull, 32'h000C_0000);
    chk("R8 slew only on outputs", slew, 32'h0003_0000);
  endtask

  task automatic t_wprot;
    wprot = 1'b1;
    wr(8'h50, 4'b1111, 32'h0);
    wr(8'h40, 4'b1111, 32'hFFFF_FFFF);
    wr(8'h00, 4'b1111, 32'h000C_0000);
    @(negedge clk);
    rd_chk("R9 cfg 0x50 held", 8'h50, 32'h1414_1414);
    rd_chk("R9 cfg 0x40 held", 8'h40, 32'h0);
    rd_chk("R9 dir still writable", 8'h00, 32'h000C_0000);
    chk("R9 pull reflects held cfg", pull, 32'h0003_0000);
    wprot = 1'b0;
    wr(8'h50, 4'b1111, 32'h0);
    @(negedge clk);
    rd_chk("R9 write after release", 8'h50, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(8'h10, 4'b1111, 32'h1234_5678);
    wr(8'h04, 4'b1111, 32'hFFFF_FFFF);
    wr(8'h60, 4'b1111, 32'hFFFF_FFFF);
    wr(8'h01, 4'b1111, 32'hFFFF_FFFF);
    wr(8'h41, 4'b1111, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R11 read 0x04", 8'h04, 32'h0);
    rd_chk("R11 read 0x30", 8'h30, 32'h0);
    rd_chk("R11 read 0x60", 8'h60, 32'h0);
    rd_chk("R11 read unaligned", 8'h11, 32'h0);
    rd_chk("R11 dir untouched", 8'h00, 32'h000C_0000);
    rd_chk("R11 out untouched", 8'h10, 32'h1234_5678);
    rd_chk("R11 cfg untouched", 8'h40, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_port_drive();
    t_periph();
    t_input();
    t_pull_slew();
    t_wprot();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule